// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A synthesizable model of a synchronous burst SRAM in which reads and writes may be mixed freely on consecutive clock cycles with no idle cycle between them. Address, control and lane write selects are registered on the rising clock edge. Read data leaves through an output register two enabled cycles after its address. Write data is taken from the bus two enabled cycles after its address, matching the read timing. Because both directions share one latency, the data bus carries one transfer per cycle whatever the mix of operations.

A load/advance input chooses between starting a new access at an external address and stepping a two-bit burst counter. The counter steps in linear or interleaved order. A clock enable freezes the entire pipeline. Three chip enables of mixed polarity select the device, and an output enable gates the data drivers. The output bus is modelled as a data vector plus a drive flag. When the flag is low the bus is released, which stands for high impedance.

Top module: `turnless_sram`

## Requirements
- R1: After reset, `dq_drv` is 0 and `dq_out` is all zeros until a read completes.
- R2: A read captured on an enabled edge N places the stored word on `dq_out` with `dq_drv` high right after enabled edge N+2.
- R3: For a write captured on enabled edge N, `wdata` is sampled on enabled edge N+2 and stored at the captured address.
- R4: Lane i is bits [8i+7:8i] and is written only when `lane_we_n[i]` is 0 at capture. All other lanes of the word keep their old value.
- R5: Reads and writes may alternate every cycle. A read of an address whose write is still in the pipeline returns the newly written lanes merged with the old ones.
- R6: In the cycle after a write's data edge, `dq_drv` is 0.
- R7: While `clk_en` is 0, no register changes. `dq_out`, `dq_drv` and every pending operation hold until enables resume.
- R8: The device is selected only when `en0_n`=0, `en1`=1 and `en2_n`=0 on a load cycle. A deselected access neither drives the bus in its data phase nor writes the array.
- R9: `oe_n`=1 forces `dq_drv` to 0 at once. It does not change the stored data.
- R10: `adv_ld`=0 loads `addr` and clears the burst count. `adv_ld`=1 increments the count and repeats the kind and selection of the last load. On such a cycle `we_n`, `addr` and the chip enables are ignored.
- R11: With `burst_ilv`=0, an advanced address keeps the upper bits of the loaded address. Its two low bits are (start + count) mod 4.
- R12: With `burst_ilv`=1, the two low bits of an advanced address are start XOR count.
- R13: Whenever `dq_drv` is 0, `dq_out` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | 1 lets the pipeline advance; 0 freezes it |
| en0_n | input | 1 | Chip enable, active low |
| en1 | input | 1 | Chip enable, active high |
| en2_n | input | 1 | Chip enable, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | 0 selects write on a load cycle |
| lane_we_n | input | LANES | Per-lane write selects, active low |
| addr | input | ADDR_W | Word address |
| burst_ilv | input | 1 | 0 linear, 1 interleaved burst order |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | LANES*LANE_W | Write data, sampled two enabled edges after the address |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_drv | output | 1 | High when the block drives the data bus |

## Verification
The bench aims at a read that directly follows a write to the same address under every lane mask. A design without bypass would return the stale word there. It also places stalls between an issued write and its data edge. A design that lets any stage slip would take the wrong `wdata` or shift every later result by one cycle. Bursts are run from all four start offsets in both orders, with `we_n` and the chip enables deliberately flipped on advance cycles. A wrong wrap, a swapped order, or sampling of ignored pins shows up as data at the wrong address. Writes with each chip enable wrong in turn must leave the array untouched. A model that gated only the bus would be caught by the read-back that follows.

// File: rtl/tsr_pkg.sv
// Shared types and helpers of the zero-turnaround SRAM.
// Assumes bursts span four words addressed by the two low address bits.
package tsr_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_kind_e;

    // Low two address bits of a burst step in linear or interleaved order.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] step,
                                             input logic       ilv);
        return ilv ? (start ^ step) : (start + step);
    endfunction

endpackage

// File: rtl/tsr_cmd.sv
// Command capture stage: registers address, kind, selection and lane mask
// on each enabled edge, and runs the two-bit burst counter.
// Assumes ADDR_W >= 3 and that advance cycles inherit the last load's kind.
module tsr_cmd
    import tsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              sel_ok,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst_ilv,
    output logic              s1_vld,
    output op_kind_e          s1_kind,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_mask
);
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nx;
    logic              last_vld_q;
    op_kind_e          last_kind_q;
    op_kind_e          new_kind;

    // Next burst count and the kind requested by a load.
    always_comb begin
        cnt_nx   = cnt_q + 2'd1;
        new_kind = we_n ? OP_RD : OP_WR;
    end

    // Capture a load or step the burst; everything holds when clk_en is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld      <= 1'b0;
            s1_kind     <= OP_RD;
            s1_addr     <= '0;
            s1_mask     <= '0;
            base_q      <= '0;
            cnt_q       <= '0;
            last_vld_q  <= 1'b0;
            last_kind_q <= OP_RD;
        end else if (clk_en) begin
            s1_mask <= ~lane_we_n;
            if (!adv_ld) begin
                base_q      <= addr;
                cnt_q       <= '0;
                last_vld_q  <= sel_ok;
                last_kind_q <= new_kind;
                s1_vld      <= sel_ok;
                s1_kind     <= new_kind;
                s1_addr     <= addr;
            end else begin
                cnt_q   <= cnt_nx;
                s1_vld  <= last_vld_q;
                s1_kind <= last_kind_q;
                s1_addr <= {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, burst_ilv)};
            end
        end
    end

endmodule

// File: rtl/tsr_store.sv
// Second pipeline stage and storage array, split into one array per lane.
// The array is read one edge ahead of the output register; a write still
// waiting for its data edge is bypassed into that read lane by lane.
// Assumes one operation per enabled cycle.
module tsr_store
    import tsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    s1_vld,
    input  op_kind_e                s1_kind,
    input  logic [ADDR_W-1:0]       s1_addr,
    input  logic [LANES-1:0]        s1_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic                    s2_vld,
    output op_kind_e                s2_kind,
    output logic [LANES*LANE_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_mask;
    logic              commit;
    logic              fwd_hit;

    // A selected write in stage 2 commits on this edge; bypass if same address.
    always_comb begin
        commit  = clk_en && s2_vld && (s2_kind == OP_WR);
        fwd_hit = s2_vld && (s2_kind == OP_WR) && (s2_addr == s1_addr);
    end

    // Stage-2 command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_vld  <= 1'b0;
            s2_kind <= OP_RD;
            s2_addr <= '0;
            s2_mask <= '0;
        end else if (clk_en) begin
            s2_vld  <= s1_vld;
            s2_kind <= s1_kind;
            s2_addr <= s1_addr;
            s2_mask <= s1_mask;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] q;

        // Lane write on the data edge when this lane is selected.
        always_ff @(posedge clk) begin
            if (commit && s2_mask[g])
                mem[s2_addr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Lane read for the stage-1 address, taking pending write data.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (clk_en)
                q <= (fwd_hit && s2_mask[g]) ? wdata[g*LANE_W +: LANE_W] : mem[s1_addr];
        end

        assign rd_word[g*LANE_W +: LANE_W] = q;
    end

endmodule

// File: rtl/turnless_sram.sv
// Zero-turnaround pipelined synchronous SRAM top: capture stage, storage
// stage and output register. Reads and writes both complete two enabled
// edges after their address. Assumes synchronous active-low reset.
module turnless_sram
    import tsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en,
    input  logic                    en0_n,
    input  logic                    en1,
    input  logic                    en2_n,
    input  logic                    adv_ld,
    input  logic                    we_n,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    burst_ilv,
    input  logic                    oe_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_drv
);
    localparam int DW = LANES * LANE_W;

    logic              sel_ok;
    logic              s1_vld;
    op_kind_e          s1_kind;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_mask;
    logic              s2_vld;
    op_kind_e          s2_kind;
    logic [DW-1:0]     rd_word;
    logic              out_vld;
    logic [DW-1:0]     out_q;

    // All three chip enables must be active.
    assign sel_ok = !en0_n && en1 && !en2_n;

    tsr_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sel_ok    (sel_ok),
        .adv_ld    (adv_ld),
        .we_n      (we_n),
        .lane_we_n (lane_we_n),
        .addr      (addr),
        .burst_ilv (burst_ilv),
        .s1_vld    (s1_vld),
        .s1_kind   (s1_kind),
        .s1_addr   (s1_addr),
        .s1_mask   (s1_mask)
    );

    tsr_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_en  (clk_en),
        .s1_vld  (s1_vld),
        .s1_kind (s1_kind),
        .s1_addr (s1_addr),
        .s1_mask (s1_mask),
        .wdata   (wdata),
        .s2_vld  (s2_vld),
        .s2_kind (s2_kind),
        .rd_word (rd_word)
    );

    // Output register: loads read data, releases the bus for writes/deselects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_q   <= '0;
        end else if (clk_en) begin
            out_vld <= s2_vld && (s2_kind == OP_RD);
            if (s2_vld && (s2_kind == OP_RD))
                out_q <= rd_word;
        end
    end

    // Bus drivers gated by the output enable.
    always_comb begin
        dq_drv = out_vld && !oe_n;
        dq_out = dq_drv ? out_q : '0;
    end

endmodule

// File: rtl/tsr_chk.sv
// Checker for turnless_sram: pipeline hold, bus release and load capture.
// Attached to every instance of the top module by the bind below.
module tsr_chk
    import tsr_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DW     = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              adv_ld,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] s1_addr,
    input logic              s2_vld,
    input op_kind_e          s2_kind,
    input logic              out_vld,
    input logic [DW-1:0]     out_q
);
    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(out_q) && $stable(out_vld)));

    // R6
    wr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_vld && s2_kind == OP_WR) |=> !out_vld);

    // R8
    desel_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !s2_vld) |=> !out_vld);

    // R2
    rd_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_vld && s2_kind == OP_RD) |=> out_vld);

    // R10
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld) |=> (s1_addr == $past(addr)));

endmodule

bind turnless_sram tsr_chk #(.ADDR_W(ADDR_W), .DW(LANES*LANE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clk_en  (clk_en),
    .adv_ld  (adv_ld),
    .addr    (addr),
    .s1_addr (s1_addr),
    .s2_vld  (s2_vld),
    .s2_kind (s2_kind),
    .out_vld (out_vld),
    .out_q   (out_q)
);

// File: tb/sim_turnless_sram.sv
// Bench for turnless_sram: sweeps, masks, bursts, stalls, selects.
module sim_turnless_sram;
    localparam int AW = 6;
    localparam int NW = 1 << AW;
    localparam logic [2:0] SEL_ON  = 3'b010;   // {en2_n, en1, en0_n}
    localparam logic [2:0] SEL_OFF = 3'b111;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        en0_n = 1'b1, en1 = 1'b0, en2_n = 1'b1;
    logic        adv_ld = 1'b0, we_n = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
    logic [3:0]  lane_we_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] dq_out;
    logic        dq_drv;

    int nchk = 0, nfail = 0, stepno = 0;
    logic [31:0] ref_mem [NW];

    // model pipeline of issued operations
    logic p1_act = 0, p1_wr = 0, p2_act = 0, p2_wr = 0;
    logic [AW-1:0] p1_a = '0, p2_a = '0;
    logic [3:0] p1_m = '0, p2_m = '0;
    logic [31:0] p1_d = '0, p2_d = '0;
    string p1_tag = "", p2_tag = "";
    // model burst state
    logic [AW-1:0] mb_base = '0;
    logic [1:0] mb_cnt = '0;
    logic mb_act = 0, mb_wr = 0;

    turnless_sram u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .en0_n(en0_n), .en1(en1),
        .en2_n(en2_n), .adv_ld(adv_ld), .we_n(we_n), .lane_we_n(lane_we_n),
        .addr(addr), .burst_ilv(burst_ilv), .oe_n(oe_n), .wdata(wdata),
        .dq_out(dq_out), .dq_drv(dq_drv)
    );

    always #5 clk = ~clk;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    endtask

    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog: actual hung, expected finish");
        summary();
    end

    function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                          input logic [3:0] m);
        logic [31:0] r = old;
        for (int i = 0; i < 4; i++)
            if (m[i]) r[i*8 +: 8] = nw[i*8 +: 8];
        return r;
    endfunction

    // One enabled cycle: issue an operation, check the one completing now.
    task automatic step(input logic adv, input logic wr, input logic [AW-1:0] a,
                        input logic [3:0] m, input logic [2:0] sel,
                        input logic ilv, input logic oen, input string tag);
        logic act, w, exp_drv;
        logic [AW-1:0] ea;
        logic [1:0] lo;
        logic [31:0] exp_q;
        if (!adv) begin
            act = (sel == SEL_ON); w = wr; ea = a;
            mb_base = a; mb_cnt = 2'd0; mb_act = act; mb_wr = w;
        end else begin
            mb_cnt = mb_cnt + 2'd1;
            act = mb_act; w = mb_wr;
            lo = ilv ? (mb_base[1:0] ^ mb_cnt) : 2'((mb_base[1:0] + mb_cnt) % 4);
            ea = {mb_base[AW-1:2], lo};
        end
        @(negedge clk);
        clk_en = 1'b1; adv_ld = adv; we_n = !wr; lane_we_n = ~m; addr = a;
        {en2_n, en1, en0_n} = sel; burst_ilv = ilv; oe_n = oen;
        wdata = (p2_act && p2_wr) ? p2_d : (32'hDEAD0000 | 32'(stepno));
        @(posedge clk);
        #2;
        nchk++;
        exp_drv = p2_act && !p2_wr && !oen;
        exp_q = exp_drv ? merge(ref_mem[p2_a], 32'h0, 4'h0) : 32'h0;
        if (dq_drv !== exp_drv) begin
            nfail++;
            $display("FAIL %s drive: actual %0b expected %0b",
                     (p2_act && p2_wr) ? "R6" : (!p2_act ? "R8" : p2_tag), dq_drv, exp_drv);
        end else if (dq_out !== exp_q) begin
            nfail++;
            $display("FAIL %s data: actual %h expected %h",
                     exp_drv ? p2_tag : "R13", dq_out, exp_q);
        end
        if (p2_act && p2_wr) ref_mem[p2_a] = merge(ref_mem[p2_a], p2_d, p2_m);
        p2_act = p1_act; p2_wr = p1_wr; p2_a = p1_a; p2_m = p1_m; p2_d = p1_d; p2_tag = p1_tag;
        p1_act = act; p1_wr = w; p1_a = ea; p1_m = m; p1_tag = tag;
        p1_d = {~stepno[15:0] ^ 16'h3C96, stepno[15:0] * 16'h9E37};
        stepno++;
    endtask

    // Freeze with clock enable low and noisy inputs; outputs must hold (R7).
    task automatic hold(input int n);
        logic [31:0] q0;
        logic d0;
        @(negedge clk);
        q0 = dq_out; d0 = dq_drv;
        clk_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            adv_ld = i[0]; we_n = ~we_n; addr = addr + 6'd13; wdata = ~wdata;
            {en2_n, en1, en0_n} = SEL_ON;
            @(posedge clk);
            #2;
            nchk++;
            if (dq_out !== q0 || dq_drv !== d0) begin
                nfail++;
                $display("FAIL R7 hold: actual %h/%0b expected %h/%0b", dq_out, dq_drv, q0, d0);
            end
            @(negedge clk);
        end
    endtask

    initial begin
        for (int i = 0; i < NW; i++) ref_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        nchk++;
        if (dq_drv !== 1'b0 || dq_out !== 32'h0) begin
            nfail++;
            $display("FAIL R1 reset: actual %h/%0b expected 0/0", dq_out, dq_drv);
        end
        // R3: fill every word back to back
        for (int a = 0; a < NW; a++) step(0, 1, AW'(a), 4'hF, SEL_ON, 0, 0, "R3");
        // R2: read every word back to back
        for (int a = 0; a < NW; a++) step(0, 0, AW'(a), 4'hF, SEL_ON, 0, 0, "R2");
        // R5: alternate write, same-address read, other read; stalls inside (R7)
        for (int a = 0; a < 32; a++) begin
            step(0, 1, AW'(a) ^ 6'h15, 4'hF, SEL_ON, 0, 0, "R5");
            if (a == 10) hold(3);
            step(0, 0, AW'(a) ^ 6'h15, 4'hF, SEL_ON, 0, 0, "R5");
            if (a == 20) hold(2);
            step(0, 0, AW'(a), 4'hF, SEL_ON, 0, 0, "R5");
        end
        // R4: every lane mask, read forwarded and read from the array
        for (int m = 0; m < 16; m++) begin
            step(0, 1, 6'd7, 4'(m), SEL_ON, 0, 0, "R4");
            step(0, 0, 6'd7, 4'hF, SEL_ON, 0, 0, "R4");
            step(0, 0, 6'd7, 4'hF, SEL_ON, 0, 0, "R4");
        end
        // R10/R11/R12: bursts from each start, both orders, ignored pins flipped
        for (int ilv = 0; ilv < 2; ilv++) begin
            for (int s = 0; s < 4; s++) begin
                step(0, 1, 6'h20 + AW'(s), 4'hF, SEL_ON, ilv[0], 0, "R10");
                for (int k = 0; k < 3; k++)
                    step(1, 0, 6'h3F, 4'hF, SEL_OFF, ilv[0], 0, ilv ? "R12" : "R11");
                step(0, 0, 6'h20 + AW'(s), 4'hF, SEL_ON, ilv[0], 0, "R10");
                for (int k = 0; k < 3; k++)
                    step(1, 1, 6'h00, 4'hF, SEL_OFF, ilv[0], 0, ilv ? "R12" : "R11");
                for (int k = 0; k < 4; k++)
                    step(0, 0, 6'h20 + AW'(k), 4'hF, SEL_ON, 0, 0, ilv ? "R12" : "R11");
            end
        end
        // R8: each chip enable wrong in turn blocks the write and the drive
        for (int b = 0; b < 3; b++) begin
            step(0, 1, 6'd9, 4'hF, SEL_ON ^ (3'd1 << b), 0, 0, "R8");
            step(0, 0, 6'd9, 4'hF, SEL_ON ^ (3'd1 << b), 0, 0, "R8");
            step(0, 0, 6'd9, 4'hF, SEL_ON, 0, 0, "R8");
        end
        // R9: output enable released on one completing read only
        step(0, 0, 6'd3, 4'hF, SEL_ON, 0, 0, "R9");
        step(0, 0, 6'd4, 4'hF, SEL_ON, 0, 0, "R9");
        step(0, 0, 6'd5, 4'hF, SEL_ON, 0, 1, "R9");
        step(0, 0, 6'd3, 4'hF, SEL_ON, 0, 0, "R9");
        step(0, 0, 6'd4, 4'hF, SEL_ON, 0, 1, "R9");
        // R13: drain with deselected cycles
        for (int i = 0; i < 3; i++) step(0, 0, 6'd0, 4'hF, SEL_OFF, 0, 0, "R13");
        summary();
    end

endmodule